// File: doc/BRIEF.md
# Programmable Asynchronous Memory Bus Sequencer

This block turns single requests from an on-chip requester into read and write bus cycles on an external asynchronous memory or peripheral. Every bus cycle is built from four phases. Setup, access and hold are each set by their own configuration input. A transition gap can also be placed after a read, which gives the external device time to stop driving the data bus. All phase lengths are counted in whole bus clock cycles.

The requester presents an address, a read/write flag, byte enables and write data with a valid signal, and the request is taken on a clock edge where the ready output is high. The block returns a one-cycle done pulse, and for reads it also returns the captured data. On the memory side it drives a one-of-N active-low bank select, which is decoded from the top address bits. It also drives the address, active-low byte enables, output enable, read and write strobes, and the write data together with its driver enable. All memory-side controls come straight from flops, so they change only on clock edges.

Top module: `async_mem_seq`

## Requirements
- R1: After reset, all bank selects, the output enable and both strobes are high, the data driver enable is low, done is low and ready is high.
- R2: On the cycle after a request is accepted, the bank select, address and byte enables (active-low, the inverse of the requested enables) become valid together. For a read, the output enable also goes low in that cycle. The setup phase lasts max(setup,1) cycles before any strobe goes low.
- R3: The read strobe, or for writes the write strobe, stays low for exactly max(access,1) cycles.
- R4: Read data is sampled on the clock edge that ends the access phase. Done is a one-cycle pulse in the first hold cycle, and the sampled data is on the read data output in that same cycle.
- R5: After the strobe rises, the bank select stays low for max(hold,1) more cycles. The whole bank-select window is therefore max(setup,1)+max(access,1)+max(hold,1) cycles.
- R6: When a read is followed at once by another request, the bank selects stay high for max(transition,1) cycles between the two accesses.
- R7: When a write is followed at once by another request, the bank selects stay high for exactly one cycle, whatever the transition setting.
- R8: A write pulses the write strobe and never the read strobe, and it keeps the output enable high. The data driver enable is high for exactly the bank-select window, and it drives the requested data.
- R9: A programmed value of zero for setup, access or hold gives a one-cycle phase.
- R10: Address bits [AW-1 -: log2(NBANK)] pick the bank, and only that bank's select line goes low. At most one bank select is ever low.
- R11: Ready is high only while the sequencer is idle or in the last transition cycle. It is low whenever a bank select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_setup | input | CW | Setup phase length in cycles |
| cfg_access | input | CW | Access (strobe) phase length in cycles |
| cfg_hold | input | CW | Hold phase length in cycles |
| cfg_trans | input | CW | Transition gap after a read |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_be | input | DW/8 | Byte enables, active high |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Captured read data |
| mem_bank_n | output | NBANK | Active-low bank selects |
| mem_addr | output | AW | Memory address |
| mem_be_n | output | DW/8 | Active-low byte enables |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_data_out | output | DW | Write data to the bus |
| mem_data_oe | output | 1 | Write data driver enable |
| mem_data_in | input | DW | Read data from the bus |

## Verification
Four timing settings are used: the 1/3/2/1 setting, an uneven 2/1/3/3 setting, all zeros, and 4/2/1/2. Each is run with back-to-back streams that mix read-then-read, read-then-write, write-then-read and write-then-write across several banks. Comparing gaps after reads with gaps after writes checks that the transition period is applied only after reads. The all-zero setting checks that each phase is clamped to one cycle. The memory model drives valid data only while the read strobe is low, so a read that samples one edge early or late returns the wrong word.

// File: rtl/async_mem_seq.sv
module async_mem_seq #(
  parameter int AW    = 24,
  parameter int DW    = 32,
  parameter int NBANK = 4,
  parameter int CW    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        cfg_setup,
  input  logic [CW-1:0]        cfg_access,
  input  logic [CW-1:0]        cfg_hold,
  input  logic [CW-1:0]        cfg_trans,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW/8-1:0]      req_be,
  input  logic [DW-1:0]        req_wdata,
  output logic                 rsp_done,
  output logic [DW-1:0]        rsp_rdata,
  output logic [NBANK-1:0]     mem_bank_n,
  output logic [AW-1:0]        mem_addr,
  output logic [DW/8-1:0]      mem_be_n,
  output logic                 mem_oe_n,
  output logic                 mem_rd_n,
  output logic                 mem_wr_n,
  output logic [DW-1:0]        mem_data_out,
  output logic                 mem_data_oe,
  input  logic [DW-1:0]        mem_data_in
);
  localparam int BW  = DW / 8;
  localparam int BKW = (NBANK > 1) ? $clog2(NBANK) : 1;

  typedef enum logic [2:0] {IDLE, SETUP, ACC, HOLD, TRN} st_t;

  st_t           st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          wr_q;

  function automatic logic [CW-1:0] len1(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  wire last   = (cnt == '0);
  assign req_ready = (st == IDLE) || (st == TRN && last);
  wire accept = req_valid && req_ready;

  always_comb begin
    st_nx  = st;
    cnt_nx = last ? cnt : cnt - 1'b1;
    case (st)
      IDLE:  if (accept) begin st_nx = SETUP; cnt_nx = len1(cfg_setup); end
      SETUP: if (last) begin st_nx = ACC; cnt_nx = len1(cfg_access); end
      ACC:   if (last) begin st_nx = HOLD; cnt_nx = len1(cfg_hold); end
      HOLD:  if (last) begin
               if (!wr_q && cfg_trans != '0) begin st_nx = TRN; cnt_nx = cfg_trans - 1'b1; end
               else st_nx = IDLE;
             end
      TRN:   if (last) begin
               if (accept) begin st_nx = SETUP; cnt_nx = len1(cfg_setup); end
               else st_nx = IDLE;
             end
      default: st_nx = IDLE;
    endcase
  end

  wire [AW-1:0] addr_src = accept ? req_addr : mem_addr;
  wire          wr_src   = accept ? req_write : wr_q;
  wire          act_nx   = (st_nx == SETUP) || (st_nx == ACC) || (st_nx == HOLD);
  wire [NBANK-1:0] sel_nx = {{(NBANK-1){1'b0}}, 1'b1} << addr_src[AW-1 -: BKW];
  wire          sample   = (st == ACC) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= IDLE;
      cnt          <= '0;
      wr_q         <= 1'b0;
      mem_addr     <= '0;
      mem_be_n     <= '1;
      mem_data_out <= '0;
      mem_bank_n   <= '1;
      mem_oe_n     <= 1'b1;
      mem_rd_n     <= 1'b1;
      mem_wr_n     <= 1'b1;
      mem_data_oe  <= 1'b0;
      rsp_done     <= 1'b0;
      rsp_rdata    <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
      if (accept) begin
        wr_q         <= req_write;
        mem_addr     <= req_addr;
        mem_be_n     <= ~req_be;
        mem_data_out <= req_wdata;
      end
      mem_bank_n  <= act_nx ? ~sel_nx : '1;
      mem_oe_n    <= !(act_nx && !wr_src);
      mem_rd_n    <= !(st_nx == ACC && !wr_src);
      mem_wr_n    <= !(st_nx == ACC && wr_src);
      mem_data_oe <= act_nx && wr_src;
      rsp_done    <= sample;
      if (sample && !wr_q) rsp_rdata <= mem_data_in;
    end
  end

  a_r2_oe_with_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> ($past(mem_bank_n) == '1 && mem_bank_n != '1));
  a_r2_setup_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd_n) |-> !$past(mem_oe_n));
  a_r4_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> ($rose(mem_rd_n) || $rose(mem_wr_n)));
  a_r8_no_oe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_data_oe |-> mem_oe_n) and !(!mem_rd_n && !mem_wr_n));
  a_r10_onehot_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_bank_n));
  a_r11_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_bank_n != '1) |-> !req_ready);
  a_r11_accept_opens_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_bank_n != '1));
endmodule

// File: tb/tb_async_mem_seq.sv
module tb_async_mem_seq;
  localparam int AW = 24, DW = 32, NB = 4, CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [CW-1:0] cs = 0, ca = 0, ch = 0, ct = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = 0;
  logic [3:0] req_be = 0;
  logic [DW-1:0] req_wdata = 0;
  logic req_ready, rsp_done, mem_oe_n, mem_rd_n, mem_wr_n, mem_data_oe;
  logic [DW-1:0] rsp_rdata, mem_data_out, mem_data_in;
  logic [NB-1:0] mem_bank_n;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be_n;

  function automatic logic [DW-1:0] mval(input logic [AW-1:0] a);
    return 32'hA500_0000 ^ {8'h00, a};
  endfunction
  assign mem_data_in = !mem_rd_n ? mval(mem_addr) : 32'hDEAD_BEEF;

  async_mem_seq #(.AW(AW), .DW(DW), .NBANK(NB), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_setup(cs), .cfg_access(ca), .cfg_hold(ch),
    .cfg_trans(ct), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_bank_n(mem_bank_n), .mem_addr(mem_addr), .mem_be_n(mem_be_n),
    .mem_oe_n(mem_oe_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_data_out(mem_data_out), .mem_data_oe(mem_data_oe),
    .mem_data_in(mem_data_in));

  typedef struct {bit wr; logic [AW-1:0] addr; logic [3:0] be; logic [DW-1:0] data;} item_t;
  item_t q[$];
  item_t cur;
  int n_chk = 0, n_fail = 0;
  bit done_all = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff(input logic [CW-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic send(input bit wr, input logic [AW-1:0] a, input logic [3:0] be, input logic [DW-1:0] d);
    item_t it;
    it.wr = wr; it.addr = a; it.be = be; it.data = d;
    q.push_back(it);
    req_valid = 1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain;
    repeat (40) @(negedge clk);
  endtask

  // monitor / scoreboard
  bit pbl = 0, psl = 0, seen = 0, havep = 0, prev_rd = 0;
  int tot = 0, setup = 0, stl = 0, gap = 100;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        bit bl, sl;
        bl = (mem_bank_n != '1);
        sl = !mem_rd_n || !mem_wr_n;
        if (bl && !pbl) begin
          if (q.size() > 0) cur = q[0];
          chk(mem_bank_n == ~(4'b1 << cur.addr[AW-1 -: 2]), "R10 bank decode", {28'h0, mem_bank_n}, {28'h0, ~(4'b1 << cur.addr[AW-1 -: 2])});
          chk(mem_addr == cur.addr, "R2 address valid", {8'h0, mem_addr}, {8'h0, cur.addr});
          chk(mem_be_n == ~cur.be, "R2 byte enables", {28'h0, mem_be_n}, {28'h0, ~cur.be});
          chk(mem_oe_n == cur.wr, "R2 R8 output enable", {31'h0, mem_oe_n}, {31'h0, cur.wr});
          if (havep && gap <= 8)
            chk(gap == (prev_rd ? eff(ct) : 1), prev_rd ? "R6 gap after read" : "R7 gap after write", gap, prev_rd ? eff(ct) : 1);
          tot = 0; setup = 0; seen = 0;
        end
        if (bl) begin
          tot++;
          if (!sl && !seen) setup++;
          chk(!req_ready, "R11 ready low while busy", {31'h0, req_ready}, 0);
        end
        chk(mem_data_oe == (bl && cur.wr), "R8 driver window", {31'h0, mem_data_oe}, {31'h0, bl && cur.wr});
        if (sl && !psl) begin
          seen = 1; stl = 0;
          chk(setup == eff(cs), "R2 R9 setup length", setup, eff(cs));
          chk(cur.wr ? (!mem_wr_n && mem_rd_n) : (!mem_rd_n && mem_wr_n), "R8 strobe kind", {30'h0, mem_rd_n, mem_wr_n}, {30'h0, !cur.wr, cur.wr});
        end
        if (sl) stl++;
        if (!sl && psl) chk(stl == eff(ca), "R3 R9 strobe length", stl, eff(ca));
        if (!bl && pbl) begin
          chk(tot == eff(cs) + eff(ca) + eff(ch), "R5 R9 window length", tot, eff(cs) + eff(ca) + eff(ch));
          gap = 0; havep = 1; prev_rd = !cur.wr;
        end
        if (!bl) gap++;
        if (rsp_done) begin
          item_t e;
          chk(q.size() > 0, "R4 unexpected done", q.size(), 1);
          if (q.size() > 0) begin
            e = q.pop_front();
            chk(!sl && psl, "R4 done in first hold cycle", {31'h0, sl}, 0);
            if (e.wr) chk(mem_data_out == e.data && mem_data_oe, "R8 write data", mem_data_out, e.data);
            else      chk(rsp_rdata == mval(e.addr), "R4 read data", rsp_rdata, mval(e.addr));
          end
        end
        pbl = bl; psl = sl;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_bank_n == '1 && mem_oe_n && mem_rd_n && mem_wr_n, "R1 idle controls", {25'h0, mem_bank_n, mem_oe_n, mem_rd_n, mem_wr_n}, 32'h7F);
    chk(!mem_data_oe && !rsp_done, "R1 driver and done", {30'h0, mem_data_oe, rsp_done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", {31'h0, req_ready}, 1);

    cs = 1; ca = 3; ch = 2; ct = 1;
    send(0, 24'h000010, 4'hF, 0);
    send(0, 24'h000014, 4'hF, 0);
    send(1, 24'h400020, 4'h3, 32'h1234_5678);
    send(0, 24'h400024, 4'hF, 0);
    drain();

    cs = 2; ca = 1; ch = 3; ct = 3;
    send(0, 24'h800100, 4'hF, 0);
    send(0, 24'h800104, 4'hF, 0);
    send(1, 24'hC00008, 4'hC, 32'hCAFE_F00D);
    send(0, 24'h400200, 4'hF, 0);
    send(1, 24'h000300, 4'h1, 32'h0BAD_CAB1);
    send(1, 24'h000304, 4'h8, 32'h5555_AAAA);
    drain();

    cs = 0; ca = 0; ch = 0; ct = 0;
    send(0, 24'hC00040, 4'hF, 0);
    send(1, 24'h800044, 4'hF, 32'h0F0F_0F0F);
    send(0, 24'h000048, 4'hF, 0);
    send(0, 24'h40004C, 4'hF, 0);
    drain();

    cs = 4; ca = 2; ch = 1; ct = 2;
    send(1, 24'h400400, 4'h6, 32'h7777_0001);
    send(0, 24'hC00404, 4'hF, 0);
    send(0, 24'hC00408, 4'hF, 0);
    drain();

    chk(q.size() == 0, "R4 all requests completed", q.size(), 0);
    done_all = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_all) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule